// File: doc/BRIEF.md
# Tree-SISO Fusion Network

This block computes forward and backward state metrics for a window of trellis steps of a two-state code in one pass. The trellis is not walked step by step with a serial add-compare-select recursion. Instead, each step is treated as a 2x2 min-plus matrix of branch costs. Adjacent sections are merged with a min-plus fusion: the cost from start state i to end state j through two sections is the cheapest choice of intermediate state p. The merges are arranged as a prefix tree, which yields every forward boundary. A mirrored suffix tree runs from the far end and yields every backward boundary. Because no result feeds back into its own computation, a register can sit after every tree level.

A window enters as one beat. The beat carries the branch matrices, a starting forward vector for boundary 0 and a closing backward vector for boundary STEPS. After log2(STEPS) fusion levels and one boundary-combine stage, the block presents the forward metric at every boundary 1..STEPS and the backward metric at every boundary 0..STEPS-1. A new window may enter on every cycle. All metric sums clamp at the largest representable value.

Top module: `tree_siso_fusion`

## Requirements
- R1: A window accepted with validIn high produces exactly one result, with validOut high exactly LEVELS+1 cycles later (4 for 8 steps); windows on consecutive cycles give results on consecutive cycles.
- R2: While rstN is low at a clock edge, the following cycle shows validOut low and fwdOut and bwdOut all zero, and a window in flight at reset never produces a result.
- R3: fwdOut field k (bits [(2k+s)*W +: W] for state s) equals the cheapest path cost from boundary 0, starting at fwdInit, to state s at boundary k+1. Branch cost for step k from state i to state j is bmIn bits [((4k)+2i+j)*W +: W]; fwdInit and bwdInit hold state s at bits [s*W +: W].
- R4: bwdOut field k (same layout as fwdOut) equals the cheapest path cost from state s at boundary k to the end of the window, ending with bwdInit at boundary STEPS.
- R5: Every addition clamps at 2^W-1 instead of wrapping; a starting vector of all-maximum values drives every metric of that direction to the maximum.
- R6: fwdOut and bwdOut stay unchanged in every cycle in which validOut is low.
- R7: For every result, the cheapest complete path seen from the last forward boundary combined with bwdInit equals the one seen from the first backward boundary combined with fwdInit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| validIn | input | 1 | Window present on the inputs this cycle |
| bmIn | input | STEPS*4*METRIC_W | Branch cost matrices, one per step, layout in R3 |
| fwdInit | input | 2*METRIC_W | Forward metrics at boundary 0 |
| bwdInit | input | 2*METRIC_W | Backward metrics at boundary STEPS |
| validOut | output | 1 | Result present on the outputs |
| fwdOut | output | STEPS*2*METRIC_W | Forward metrics at boundaries 1..STEPS |
| bwdOut | output | STEPS*2*METRIC_W | Backward metrics at boundaries 0..STEPS-1 |

## Verification
The hardest behaviour to reach from the ports is clamping that happens inside intermediate fusions. There, a partial sum saturates in the tree in a different grouping than it does in a serial walk, and the result must still match. The stimulus reaches this with windows of near-maximum costs and with windows in which every branch is at the maximum except one cheap path through the whole window. These windows are streamed back to back so that every pipeline stage holds a different pattern, and the stream is broken with idle gaps to expose the hold behaviour. A reset in the middle of the stream confirms that a window in flight is dropped.

// File: rtl/tsfn_pkg.sv
package tsfn_pkg;
  localparam int NUM_ST = 2;
  localparam int MAT_ENTRIES = NUM_ST * NUM_ST;

  // Per-stage command from control to datapath
  typedef struct packed {
    logic clear;
    logic load;
  } stage_strobe_t;
endpackage

// File: rtl/tsfn_level.sv
// One Kogge-Stone level: prefix fuses with the section DIST steps earlier,
// suffix fuses with the section DIST steps later. Purely combinational.
module tsfn_level #(
  parameter int STEPS = 8,
  parameter int W = 8,
  parameter int DIST = 1
) (
  input  logic [STEPS-1:0][4*W-1:0] preIn,
  input  logic [STEPS-1:0][4*W-1:0] sufIn,
  output logic [STEPS-1:0][4*W-1:0] preOut,
  output logic [STEPS-1:0][4*W-1:0] sufOut
);
  function automatic logic [W-1:0] satAdd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] sum;
    sum = {1'b0, a} + {1'b0, b};
    return sum[W] ? {W{1'b1}} : sum[W-1:0];
  endfunction

  // min-plus product: earlier section first, later section second
  function automatic logic [4*W-1:0] fuse(input logic [4*W-1:0] first, input logic [4*W-1:0] second);
    logic [4*W-1:0] res;
    logic [W-1:0] viaZero;
    logic [W-1:0] viaOne;
    res = '0;
    for (int i = 0; i < 2; i++) begin
      for (int j = 0; j < 2; j++) begin
        viaZero = satAdd(first[(i*2+0)*W +: W], second[(0*2+j)*W +: W]);
        viaOne  = satAdd(first[(i*2+1)*W +: W], second[(1*2+j)*W +: W]);
        res[(i*2+j)*W +: W] = (viaOne < viaZero) ? viaOne : viaZero;
      end
    end
    return res;
  endfunction

  for (genvar k = 0; k < STEPS; k++) begin : g_step
    if (k >= DIST) begin : g_preFuse
      assign preOut[k] = fuse(preIn[k-DIST], preIn[k]);
    end else begin : g_prePass
      assign preOut[k] = preIn[k];
    end
    if (k + DIST < STEPS) begin : g_sufFuse
      assign sufOut[k] = fuse(sufIn[k], sufIn[k+DIST]);
    end else begin : g_sufPass
      assign sufOut[k] = sufIn[k];
    end
  end
endmodule

// File: rtl/tsfn_ctrl.sv
// Occupancy tracking and per-stage load/clear strobes.
module tsfn_ctrl #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic validIn,
  output logic validOut,
  output tsfn_pkg::stage_strobe_t [LAT-1:0] strobes
);
  logic [LAT-1:0] occupied;

  always_ff @(posedge clk) begin
    if (!rstN) occupied <= '0;
    else       occupied <= {occupied[LAT-2:0], validIn};
  end

  for (genvar s = 0; s < LAT; s++) begin : g_strobe
    assign strobes[s].clear = !rstN;
    if (s == 0) begin : g_head
      assign strobes[s].load = validIn;
    end else begin : g_body
      assign strobes[s].load = occupied[s-1];
    end
  end

  assign validOut = occupied[LAT-1];
endmodule

// File: rtl/tsfn_datapath.sv
// Prefix/suffix fusion tree with a register after each level, then a
// boundary-combine stage that applies the window's edge vectors.
module tsfn_datapath #(
  parameter int STEPS = 8,
  parameter int W = 8
) (
  input  logic clk,
  input  tsfn_pkg::stage_strobe_t [$clog2(STEPS):0] strobes,
  input  logic [STEPS-1:0][4*W-1:0] bmIn,
  input  logic [2*W-1:0] fwdInit,
  input  logic [2*W-1:0] bwdInit,
  output logic [STEPS-1:0][2*W-1:0] fwdOut,
  output logic [STEPS-1:0][2*W-1:0] bwdOut
);
  localparam int LEVELS = $clog2(STEPS);
  localparam int MW = 4 * W;
  localparam int VW = 2 * W;

  logic [STEPS-1:0][MW-1:0] lvlPreIn  [LEVELS];
  logic [STEPS-1:0][MW-1:0] lvlSufIn  [LEVELS];
  logic [STEPS-1:0][MW-1:0] lvlPreNxt [LEVELS];
  logic [STEPS-1:0][MW-1:0] lvlSufNxt [LEVELS];
  logic [STEPS-1:0][MW-1:0] preQ      [LEVELS];
  logic [STEPS-1:0][MW-1:0] sufQ      [LEVELS];
  logic [VW-1:0] lvlFwdIn [LEVELS];
  logic [VW-1:0] lvlBwdIn [LEVELS];
  logic [VW-1:0] fwdEdgeQ [LEVELS];
  logic [VW-1:0] bwdEdgeQ [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    if (l == 0) begin : g_first
      assign lvlPreIn[l] = bmIn;
      assign lvlSufIn[l] = bmIn;
      assign lvlFwdIn[l] = fwdInit;
      assign lvlBwdIn[l] = bwdInit;
    end else begin : g_chain
      assign lvlPreIn[l] = preQ[l-1];
      assign lvlSufIn[l] = sufQ[l-1];
      assign lvlFwdIn[l] = fwdEdgeQ[l-1];
      assign lvlBwdIn[l] = bwdEdgeQ[l-1];
    end

    tsfn_level #(
      .STEPS(STEPS),
      .W(W),
      .DIST(1 << l)
    ) u_level (
      .preIn(lvlPreIn[l]),
      .sufIn(lvlSufIn[l]),
      .preOut(lvlPreNxt[l]),
      .sufOut(lvlSufNxt[l])
    );
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LEVELS; l++) begin
      if (strobes[l].clear) begin
        preQ[l]     <= '0;
        sufQ[l]     <= '0;
        fwdEdgeQ[l] <= '0;
        bwdEdgeQ[l] <= '0;
      end else if (strobes[l].load) begin
        preQ[l]     <= lvlPreNxt[l];
        sufQ[l]     <= lvlSufNxt[l];
        fwdEdgeQ[l] <= lvlFwdIn[l];
        bwdEdgeQ[l] <= lvlBwdIn[l];
      end
    end
  end

  function automatic logic [W-1:0] satAdd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] sum;
    sum = {1'b0, a} + {1'b0, b};
    return sum[W] ? {W{1'b1}} : sum[W-1:0];
  endfunction

  logic [STEPS-1:0][VW-1:0] fwdNext;
  logic [STEPS-1:0][VW-1:0] bwdNext;

  always_comb begin
    logic [W-1:0] best;
    logic [W-1:0] cand;
    fwdNext = '0;
    bwdNext = '0;
    for (int k = 0; k < STEPS; k++) begin
      // forward: edge vector at boundary 0 through prefix k
      for (int j = 0; j < 2; j++) begin
        best = {W{1'b1}};
        for (int i = 0; i < 2; i++) begin
          cand = satAdd(fwdEdgeQ[LEVELS-1][i*W +: W], preQ[LEVELS-1][k][(i*2+j)*W +: W]);
          if (cand < best) best = cand;
        end
        fwdNext[k][j*W +: W] = best;
      end
      // backward: suffix k through edge vector at boundary STEPS
      for (int i = 0; i < 2; i++) begin
        best = {W{1'b1}};
        for (int j = 0; j < 2; j++) begin
          cand = satAdd(sufQ[LEVELS-1][k][(i*2+j)*W +: W], bwdEdgeQ[LEVELS-1][j*W +: W]);
          if (cand < best) best = cand;
        end
        bwdNext[k][i*W +: W] = best;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes[LEVELS].clear) begin
      fwdOut <= '0;
      bwdOut <= '0;
    end else if (strobes[LEVELS].load) begin
      fwdOut <= fwdNext;
      bwdOut <= bwdNext;
    end
  end
endmodule

// File: rtl/tree_siso_fusion.sv
module tree_siso_fusion #(
  parameter int STEPS = 8,
  parameter int METRIC_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic validIn,
  input  logic [STEPS*4*METRIC_W-1:0] bmIn,
  input  logic [2*METRIC_W-1:0] fwdInit,
  input  logic [2*METRIC_W-1:0] bwdInit,
  output logic validOut,
  output logic [STEPS*2*METRIC_W-1:0] fwdOut,
  output logic [STEPS*2*METRIC_W-1:0] bwdOut
);
  localparam int LEVELS = $clog2(STEPS);
  localparam int LAT = LEVELS + 1;

  tsfn_pkg::stage_strobe_t [LAT-1:0] strobes;
  logic [STEPS-1:0][2*METRIC_W-1:0] fwdVec;
  logic [STEPS-1:0][2*METRIC_W-1:0] bwdVec;

  tsfn_ctrl #(
    .LAT(LAT)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .validIn(validIn),
    .validOut(validOut),
    .strobes(strobes)
  );

  tsfn_datapath #(
    .STEPS(STEPS),
    .W(METRIC_W)
  ) u_dp (
    .clk(clk),
    .strobes(strobes),
    .bmIn(bmIn),
    .fwdInit(fwdInit),
    .bwdInit(bwdInit),
    .fwdOut(fwdVec),
    .bwdOut(bwdVec)
  );

  assign fwdOut = fwdVec;
  assign bwdOut = bwdVec;
endmodule

// File: rtl/tsfn_checker.sv
module tsfn_checker #(
  parameter int STEPS = 8,
  parameter int METRIC_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic validIn,
  input logic [4*METRIC_W-1:0] firstBm,
  input logic [2*METRIC_W-1:0] fwdInit,
  input logic [2*METRIC_W-1:0] bwdInit,
  input logic validOut,
  input logic [STEPS*2*METRIC_W-1:0] fwdOut,
  input logic [STEPS*2*METRIC_W-1:0] bwdOut
);
  localparam int W = METRIC_W;
  localparam int LAT = $clog2(STEPS) + 1;

  logic [3:0] sinceRst;
  logic armed;

  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 4'hF) sinceRst <= sinceRst + 4'd1;
  end
  assign armed = (sinceRst >= 4'(LAT));

  function automatic logic [W-1:0] sAdd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[W] ? {W{1'b1}} : s[W-1:0];
  endfunction

  function automatic logic [2*W-1:0] stepOne(input logic [2*W-1:0] f0, input logic [4*W-1:0] m);
    logic [2*W-1:0] r;
    logic [W-1:0] a;
    logic [W-1:0] b;
    for (int j = 0; j < 2; j++) begin
      a = sAdd(f0[0 +: W], m[(0*2+j)*W +: W]);
      b = sAdd(f0[W +: W], m[(1*2+j)*W +: W]);
      r[j*W +: W] = (b < a) ? b : a;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] joinCost(input logic [2*W-1:0] x, input logic [2*W-1:0] y);
    logic [W-1:0] a;
    logic [W-1:0] b;
    a = sAdd(x[0 +: W], y[0 +: W]);
    b = sAdd(x[W +: W], y[W +: W]);
    return (b < a) ? b : a;
  endfunction

  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (validOut == $past(validIn, LAT)));

  p_reset_clears_r2: assert property (@(posedge clk)
    !rstN |=> (!validOut && fwdOut == '0 && bwdOut == '0));

  p_first_boundary_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && validOut) |->
      (fwdOut[2*W-1:0] == stepOne($past(fwdInit, LAT), $past(firstBm, LAT))));

  p_saturate_fwd_r5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && validOut && $past(fwdInit, LAT) == '1) |-> (fwdOut == '1));

  p_saturate_bwd_r5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && validOut && $past(bwdInit, LAT) == '1) |-> (bwdOut == '1));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 4'd0 && !validOut) |-> ($stable(fwdOut) && $stable(bwdOut)));

  p_window_consistent_r7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && validOut) |->
      (joinCost(fwdOut[(STEPS-1)*2*W +: 2*W], $past(bwdInit, LAT)) ==
       joinCost(bwdOut[2*W-1:0], $past(fwdInit, LAT))));
endmodule

bind tree_siso_fusion tsfn_checker #(
  .STEPS(STEPS),
  .METRIC_W(METRIC_W)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .validIn(validIn),
  .firstBm(bmIn[4*METRIC_W-1:0]),
  .fwdInit(fwdInit),
  .bwdInit(bwdInit),
  .validOut(validOut),
  .fwdOut(fwdOut),
  .bwdOut(bwdOut)
);

// File: tb/sim_tree_siso_fusion.sv
module sim_tree_siso_fusion;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS = 8;
  localparam int W = 8;
  localparam int LAT = 4;
  localparam int BMW = STEPS * 4 * W;
  localparam int VW = 2 * W;
  localparam int OW = STEPS * 2 * W;
  localparam int NWIN = 420;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0;
  logic [BMW-1:0] bmIn = '0;
  logic [VW-1:0] fwdInit = '0;
  logic [VW-1:0] bwdInit = '0;
  logic validOut;
  logic [OW-1:0] fwdOut;
  logic [OW-1:0] bwdOut;

  tree_siso_fusion #(.STEPS(STEPS), .METRIC_W(W)) u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .bmIn(bmIn),
    .fwdInit(fwdInit), .bwdInit(bwdInit), .validOut(validOut),
    .fwdOut(fwdOut), .bwdOut(bwdOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  logic [31:0] lf = 32'h1234_5678;

  logic [OW-1:0] expF [64];
  logic [OW-1:0] expB [64];
  int expCyc [64];
  int expMode [64];
  int wrP = 0;
  int rdP = 0;
  logic monOn = 1'b1;
  logic haveLast = 1'b0;
  logic [OW-1:0] lastF;
  logic [OW-1:0] lastB;

  function automatic logic [31:0] rnd();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
    return lf;
  endfunction

  function automatic logic [W-1:0] sadd(input logic [W-1:0] a, input logic [W-1:0] b);
    int s;
    s = int'(a) + int'(b);
    return (s > (1 << W) - 1) ? {W{1'b1}} : W'(s);
  endfunction

  // serial walk of the trellis, one step at a time
  task automatic refModel(input logic [BMW-1:0] bm, input logic [VW-1:0] f0,
                          input logic [VW-1:0] bk, output logic [OW-1:0] fw,
                          output logic [OW-1:0] bw);
    logic [W-1:0] cur [2];
    logic [W-1:0] nxt [2];
    logic [W-1:0] c;
    cur[0] = f0[0 +: W];
    cur[1] = f0[W +: W];
    for (int k = 0; k < STEPS; k++) begin
      for (int j = 0; j < 2; j++) begin
        nxt[j] = {W{1'b1}};
        for (int i = 0; i < 2; i++) begin
          c = sadd(cur[i], bm[(k*4 + i*2 + j)*W +: W]);
          if (c < nxt[j]) nxt[j] = c;
        end
      end
      for (int s = 0; s < 2; s++) begin
        cur[s] = nxt[s];
        fw[(k*2 + s)*W +: W] = nxt[s];
      end
    end
    cur[0] = bk[0 +: W];
    cur[1] = bk[W +: W];
    for (int k = STEPS - 1; k >= 0; k--) begin
      for (int i = 0; i < 2; i++) begin
        nxt[i] = {W{1'b1}};
        for (int j = 0; j < 2; j++) begin
          c = sadd(bm[(k*4 + i*2 + j)*W +: W], cur[j]);
          if (c < nxt[i]) nxt[i] = c;
        end
      end
      for (int s = 0; s < 2; s++) begin
        cur[s] = nxt[s];
        bw[(k*2 + s)*W +: W] = nxt[s];
      end
    end
  endtask

  function automatic logic [W-1:0] rv(input int mode);
    logic [31:0] r;
    r = rnd();
    case (mode)
      0: return W'(r[2:0]);
      2: return W'(200 + (r % 56));
      3: return '0;
      default: return r[W-1:0];
    endcase
  endfunction

  task automatic genWindow(input int mode, output logic [BMW-1:0] bm,
                           output logic [VW-1:0] f0, output logic [VW-1:0] bk);
    logic [31:0] pathBits;
    int a;
    int b;
    for (int e = 0; e < STEPS*4; e++) bm[e*W +: W] = rv((mode >= 4) ? 1 : mode);
    for (int s = 0; s < 2; s++) begin
      f0[s*W +: W] = rv((mode >= 4) ? 0 : mode);
      bk[s*W +: W] = rv((mode >= 4) ? 0 : mode);
    end
    if (mode == 4) f0 = '1;
    if (mode == 5) bk = '1;
    if (mode == 6) begin
      bm = '1;
      pathBits = rnd();
      for (int k = 0; k < STEPS; k++) begin
        a = int'(pathBits[k]);
        b = int'(pathBits[k+1]);
        bm[(k*4 + a*2 + b)*W +: W] = W'(pathBits[k+9 +: 2]);
      end
    end
  endtask

  task automatic sendWindow(input int mode);
    logic [BMW-1:0] bm;
    logic [VW-1:0] f0;
    logic [VW-1:0] bk;
    logic [OW-1:0] fw;
    logic [OW-1:0] bw;
    genWindow(mode, bm, f0, bk);
    refModel(bm, f0, bk, fw, bw);
    @(negedge clk);
    bmIn = bm;
    fwdInit = f0;
    bwdInit = bk;
    validIn = 1'b1;
    expF[wrP % 64] = fw;
    expB[wrP % 64] = bw;
    expCyc[wrP % 64] = cyc;
    expMode[wrP % 64] = mode;
    wrP = wrP + 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      validIn = 1'b0;
      bmIn = {BMW/32{rnd()}};
    end
  endtask

  // result monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && monOn) begin
        if (validOut) begin
          if (rdP == wrP) begin
            total++; bad++;
            $display("FAIL R1: result with no window pending, actual validOut=1 expected 0");
          end else begin
            int idx;
            idx = rdP % 64;
            total++;
            if (cyc - expCyc[idx] != LAT) begin
              bad++;
              $display("FAIL R1: latency actual=%0d expected=%0d", cyc - expCyc[idx], LAT);
            end
            total++;
            if (fwdOut !== expF[idx]) begin
              bad++;
              $display("FAIL %s: forward actual=%h expected=%h",
                       (expMode[idx] == 4 || expMode[idx] == 2) ? "R5" : "R3", fwdOut, expF[idx]);
            end
            total++;
            if (bwdOut !== expB[idx]) begin
              bad++;
              $display("FAIL %s: backward actual=%h expected=%h",
                       (expMode[idx] == 5 || expMode[idx] == 2) ? "R5" : "R4", bwdOut, expB[idx]);
            end
            rdP = rdP + 1;
            lastF = fwdOut;
            lastB = bwdOut;
            haveLast = 1'b1;
          end
        end else if (haveLast) begin
          total++;
          if (fwdOut !== lastF || bwdOut !== lastB) begin
            bad++;
            $display("FAIL R6: idle output changed actual=%h/%h expected=%h/%h",
                     fwdOut, bwdOut, lastF, lastB);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    total++;
    if (validOut !== 1'b0 || fwdOut !== '0 || bwdOut !== '0) begin
      bad++;
      $display("FAIL R2: reset state actual=%b/%h/%h expected=0/0/0", validOut, fwdOut, bwdOut);
    end
    @(negedge clk);
    rstN = 1'b1;
    idle(2);

    // streamed windows, every mode, with occasional gaps (R1, R3, R4, R5, R7)
    for (int n = 0; n < NWIN; n++) begin
      sendWindow(n % 7);
      if ((n % 13) == 12) idle(1 + (n % 5));
    end
    idle(LAT + 4);

    // R7-style check on a known all-zero window: every metric is zero
    sendWindow(3);
    idle(LAT + 3);

    total++;
    if (rdP != wrP) begin
      bad++;
      $display("FAIL R1: results actual=%0d expected=%0d", rdP, wrP);
    end

    // R2: reset with a window in flight; it must never emerge
    @(negedge clk);
    monOn = 1'b0;
    bmIn = '0;
    fwdInit = 16'h0102;
    bwdInit = 16'h0304;
    validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < LAT + 3; i++) begin
      total++;
      if (validOut !== 1'b0 || fwdOut !== '0 || bwdOut !== '0) begin
        bad++;
        $display("FAIL R2: after reset actual=%b/%h/%h expected=0/0/0", validOut, fwdOut, bwdOut);
      end
      @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule